// File: doc/BRIEF.md
# Burst-of-Four Dual-Port Synchronous Static Memory

This block is an on-chip static memory with a write port and a read port that work side by side. Every access moves exactly four words. The block runs from a single double-rate clock `clk`. Each rising edge of `clk` stands for one half-cycle of a K/K# clock pair, and the edges alternate between K and K#. The edges are grouped into windows of four. The edges of one window are numbered 0 (K), 1 (K#), 2 (K) and 3 (K#). The first rising edge after `rst_n` goes high is edge 0 of the first window. Each window then takes at most one new write and at most one new read. The write request is taken on edge 0 and the read request on edge 2.

Write data follows its request late. A request taken on edge 0 of a window brings its four beats on the next four edges, counting from edge 2 of that window. Each beat carries its own active-low byte-lane mask. A read request is registered on edge 2 of a window. Its four beats come out three half-cycles later, one per half-cycle, marked by `rvalid`. `rvalid` stands in for echo clocks.

The read stream has no ready input. The consumer must accept every beat while `rvalid` is high, and the block never stalls. All inputs are registered before use.

Top module: `qb_burst_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read beat, `rvalid` is 0 and `rdata` is all zeros.
- R2: A low `wr_n` is acted on only at edge 0 of a window, and a low `rd_n` only at edge 2. A low enable at any other edge has no effect on the memory or on `rvalid`.
- R3: For a write request taken at edge 0 of window n (absolute edge 4n), write beats 0 to 3 are sampled from `wdata`/`wbe_n` at absolute edges 4n+2, 4n+3, 4n+4 and 4n+5.
- R4: For a read request taken at absolute edge 4n+2, beat i (i = 0..3) is driven on `rdata` from edge 4n+5+i until the next edge.
- R5: `rvalid` is high exactly on the half-cycles that carry read beats: four per read, continuous across reads in consecutive windows, and low otherwise.
- R6: Beat i of a burst uses word address {`addr`[ADDR_W-1:2], i}. The two low address bits of the request are ignored.
- R7: `wbe_n` bit l (1 = keep) guards byte lane l, bits [l*LANE_W +: LANE_W], of its beat. A kept lane keeps its old contents.
- R8: A read and a write in the same window, to the same or different bursts, both complete correctly.
- R9: A read in the same window as a write to the same burst returns the newly written lanes. A read one window before a write returns the old data.
- R10: With both enables high (inactive), no word is written and no read beat appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is one K or K# half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Active-low write request, used at window edge 0 |
| rd_n | input | 1 | Active-low read request, used at window edge 2 |
| addr | input | ADDR_W | Shared burst address (write at edge 0, read at edge 2) |
| wdata | input | LANES*LANE_W | Write beat data |
| wbe_n | input | LANES | Active-low per-lane write mask for the current beat |
| rdata | output | LANES*LANE_W | Read beat data |
| rvalid | output | 1 | High on each half-cycle that carries a read beat |

## Verification
The assertions assume that the inputs are known after reset. They also assume that the window phase counts from the first edge after reset, so request timing is judged against edge numbers and not against any external K reference. The stimulus keeps to this by driving every input on falling edges, releasing reset on a falling edge, and stepping through whole four-edge windows. Stray low enables are placed only in the off-slot edges, so the request assertions still see well-formed slots. Write beats of one window spill into edges 0 and 1 of the next, and the driver carries them across so that the burst overlap is exercised.

// File: rtl/qb_pkg.sv
package qb_pkg;
  // Position of a double-rate edge inside a four-edge window.
  typedef enum logic [1:0] {
    TK_WSLOT   = 2'd0,  // K edge: write request slot
    TK_WSLOT_N = 2'd1,  // K# edge
    TK_RSLOT   = 2'd2,  // K edge: read request slot
    TK_RSLOT_N = 2'd3   // K# edge
  } tick_e;

  localparam int unsigned BEAT_W = 2;  // four beats per burst
endpackage

// File: rtl/qb_phase.sv
module qb_phase
  import qb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output tick_e tick
);
  always_ff @(posedge clk) begin
    if (!rst_n) tick <= TK_WSLOT;
    else        tick <= tick_e'(2'(tick + 2'd1));
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TK_RSLOT) |=> (tick == TK_RSLOT_N)) else $error("phase step"); // R2
endmodule

// File: rtl/qb_array.sv
module qb_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdat,
  input  logic [LANES-1:0]        wmask_n,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && !wmask_n[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdat[l*LANE_W +: LANE_W];
    end
  end

  assign rword = mem[raddr];

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(waddr)) else $error("write address unknown"); // R6
endmodule

// File: rtl/qb_wr_path.sv
module qb_wr_path
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tick_e                   tick,
  input  logic                    wr_n,
  input  logic [ADDR_W-3:0]       base_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wbe_n,
  output logic                    we,
  output logic [ADDR_W-1:0]       waddr,
  output logic [LANES*LANE_W-1:0] wdat,
  output logic [LANES-1:0]        wmask_n
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              req_v;
  logic [ADDR_W-3:0] req_base;
  logic [ADDR_W-3:0] base;
  logic              act;
  logic [BEAT_W-1:0] beat;
  logic [DATA_W-1:0] d_q;
  logic [LANES-1:0]  m_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_v    <= 1'b0;
      req_base <= '0;
      base     <= '0;
      act      <= 1'b0;
      beat     <= '0;
      d_q      <= '0;
      m_q      <= '1;
    end else begin
      d_q <= wdata;
      m_q <= wbe_n;
      if (tick == TK_WSLOT) begin
        req_v    <= !wr_n;
        req_base <= base_in;
      end
      if (act) begin
        beat <= beat + 2'd1;
        if (beat == 2'd3) act <= 1'b0;
      end
      if (tick == TK_RSLOT && req_v) begin
        act  <= 1'b1;
        beat <= '0;
        base <= req_base;
      end
    end
  end

  assign we      = act;
  assign waddr   = {base, beat};
  assign wdat    = d_q;
  assign wmask_n = m_q;

  AST_WR_BEAT0_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (act && tick == TK_RSLOT_N) |-> (beat == 2'd0)) else $error("write beat align"); // R3
  AST_WR_ACCEPT_TO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TK_WSLOT && !wr_n) |-> ##3 (act && beat == 2'd0)) else $error("write start"); // R3
  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TK_WSLOT && wr_n) |-> ##3 !act) else $error("write without request"); // R10
endmodule

// File: rtl/qb_rd_path.sv
module qb_rd_path
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tick_e                   tick,
  input  logic                    rd_n,
  input  logic [ADDR_W-3:0]       base_in,
  input  logic [LANES*LANE_W-1:0] rword,
  output logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  logic              req_v;
  logic [ADDR_W-3:0] req_base;
  logic [ADDR_W-3:0] base;
  logic              act;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_v    <= 1'b0;
      req_base <= '0;
      base     <= '0;
      act      <= 1'b0;
      beat     <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      if (tick == TK_RSLOT) begin
        req_v    <= !rd_n;
        req_base <= base_in;
      end
      if (act) begin
        rdata  <= rword;
        rvalid <= 1'b1;
        beat   <= beat + 2'd1;
        if (beat == 2'd3) act <= 1'b0;
      end else begin
        rvalid <= 1'b0;
      end
      if (tick == TK_WSLOT && req_v) begin
        act  <= 1'b1;
        beat <= '0;
        base <= req_base;
      end
    end
  end

  assign raddr = {base, beat};

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TK_RSLOT && !rd_n) |-> ##4 rvalid) else $error("read latency"); // R4
  AST_RD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid) else $error("short read run"); // R5
  AST_RD_BEAT0_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (act && tick == TK_WSLOT_N) |-> (beat == 2'd0)) else $error("read beat align"); // R6
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == TK_RSLOT && rd_n) |-> ##4 !rvalid) else $error("read without request"); // R10
endmodule

// File: rtl/qb_burst_sram.sv
module qb_burst_sram
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wbe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  tick_e             tick;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] wdat;
  logic [DATA_W-1:0] rword;
  logic [LANES-1:0]  wmask_n;
  logic              unused_addr_lo;

  assign unused_addr_lo = ^addr[1:0];

  qb_phase u_phase (.clk(clk), .rst_n(rst_n), .tick(tick));

  qb_wr_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_n(wr_n),
    .base_in(addr[ADDR_W-1:2]), .wdata(wdata), .wbe_n(wbe_n),
    .we(we), .waddr(waddr), .wdat(wdat), .wmask_n(wmask_n)
  );

  qb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdat(wdat),
    .wmask_n(wmask_n), .raddr(raddr), .rword(rword)
  );

  qb_rd_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_n(rd_n),
    .base_in(addr[ADDR_W-1:2]), .rword(rword),
    .raddr(raddr), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: tb/qb_burst_sram_test.sv
module qb_burst_sram_test;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam logic [DW-1:0] JUNK = 36'hBADC0FFEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic rd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [LN-1:0] wbe_n = '1;
  wire  [DW-1:0] rdata;
  wire           rvalid;

  always #10 clk = ~clk;  // 50 MHz

  qb_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
    .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int errors = 0;
  int tcount = 0;
  int win = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) tcount <= tcount + 1;

  logic [DW-1:0] mdl [0:(1<<AW)-1];
  logic [DW-1:0] exp_d[$];
  int            exp_t[$];
  string         exp_tag[$];
  logic [DW-1:0] wd [4];
  logic [LN-1:0] wm [4];
  logic [DW-1:0] pend_d2 = JUNK, pend_d3 = JUNK;
  logic [LN-1:0] pend_m2 = '1, pend_m3 = '1;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_burst(input logic [DW-1:0] seed, input logic [LN-1:0] m0, m1, m2, m3);
    for (int b = 0; b < 4; b++) wd[b] = seed + DW'(b) * 36'h021084211;
    wm[0] = m0; wm[1] = m1; wm[2] = m2; wm[3] = m3;
  endtask

  // One four-edge window; called at a falling edge just before window edge 0.
  task automatic window(input bit we, input logic [AW-1:0] wa, input bit re,
                        input logic [AW-1:0] ra, input string tag, input bit stray);
    if (we)
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < LN; l++)
          if (!wm[b][l]) mdl[{wa[AW-1:2], 2'(b)}][l*LW +: LW] = wd[b][l*LW +: LW];
    if (re)
      for (int b = 0; b < 4; b++) begin
        exp_d.push_back(mdl[{ra[AW-1:2], 2'(b)}]);
        exp_t.push_back(win*4 + 6 + b);
        exp_tag.push_back(tag);
      end
    wr_n = !we; rd_n = !stray; addr = wa; wdata = pend_d2; wbe_n = pend_m2;
    @(negedge clk);
    wr_n = !stray; rd_n = !stray; addr = wa; wdata = pend_d3; wbe_n = pend_m3;
    @(negedge clk);
    wr_n = !stray; rd_n = !re; addr = ra;
    wdata = we ? wd[0] : JUNK; wbe_n = we ? wm[0] : '0;
    @(negedge clk);
    wr_n = !stray; rd_n = !stray; addr = wa;
    wdata = we ? wd[1] : JUNK; wbe_n = we ? wm[1] : '0;
    pend_d2 = we ? wd[2] : JUNK; pend_m2 = we ? wm[2] : '0;
    pend_d3 = we ? wd[3] : JUNK; pend_m3 = we ? wm[3] : '0;
    @(negedge clk);
    win++;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin : mon
    logic [DW-1:0] ed;
    int et;
    string eg;
    if (rst_n && !done && rvalid) begin
      checks++;
      if (exp_d.size() == 0) begin
        errors++;
        $display("FAIL R5 rvalid at tick %0d rdata=%h, expected no beat", tcount, rdata);
      end else begin
        ed = exp_d.pop_front(); et = exp_t.pop_front(); eg = exp_tag.pop_front();
        if (rdata !== ed || tcount != et) begin
          errors++;
          $display("FAIL %s rdata=%h tick=%0d expected rdata=%h tick=%0d", eg, rdata, tcount, ed, et);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (rvalid !== 1'b0 || rdata !== '0) begin
      errors++;
      $display("FAIL R1 rvalid=%b rdata=%h expected 0 and 0", rvalid, rdata);
    end
    rst_n = 1'b1;
    // R3: late write, all lanes
    set_burst(36'h100000001, 4'h0, 4'h0, 4'h0, 4'h0);
    window(1, 8'h10, 0, 8'h00, "R3", 0);
    // R6: low address bits ignored; R8: write in parallel
    set_burst(36'h200000002, 4'h0, 4'h0, 4'h0, 4'h0);
    window(1, 8'h30, 1, 8'h13, "R6", 0);
    set_burst(36'h300000003, 4'h0, 4'h0, 4'h0, 4'h0);
    window(1, 8'h22, 1, 8'h30, "R8", 0);
    // R7 lane masks, R9 same-window coherency
    set_burst(36'hF0F0F0F0F, 4'b0101, 4'b1010, 4'b0000, 4'b1111);
    window(1, 8'h20, 1, 8'h20, "R9", 0);
    window(0, 8'h00, 1, 8'h21, "R7", 0);
    set_burst(36'h555555555, 4'h0, 4'h0, 4'h0, 4'h0);
    window(1, 8'h20, 1, 8'h10, "R4", 0);
    // R5: back-to-back reads give a continuous valid run
    window(0, 8'h00, 1, 8'h20, "R5", 0);
    window(0, 8'h00, 1, 8'h10, "R5", 0);
    window(0, 8'h00, 1, 8'h30, "R5", 0);
    // R2: off-slot enables ignored
    window(0, 8'h30, 0, 8'h30, "R2", 1);
    window(0, 8'h00, 1, 8'h30, "R2", 0);
    // R10: inactive enables with live address and data
    window(0, 8'h10, 0, 8'h10, "R10", 0);
    window(0, 8'h00, 1, 8'h10, "R10", 0);
    for (int i = 0; i < 3; i++) window(0, 8'h00, 0, 8'h00, "R5", 0);
    done = 1'b1;
    checks++;  // R4: every expected beat appeared
    if (exp_d.size() != 0) begin
      errors++;
      $display("FAIL R4 beats left=%0d expected 0", exp_d.size());
    end
    finish_run();
  end
endmodule